// File: doc/BRIEF.md
# Trace Stream Halt Detector

This block watches a byte-wide trace bus. The bus carries processor-status and debug-data nibbles, one byte per clock. Each byte is read as two nibbles: the upper nibble is taken first and the lower nibble second. A status nibble of 0xF means that the core has stopped. A data byte of 0xFF looks the same on the bus, so a single 0xF nibble proves nothing by itself. Data can only appear after a marker nibble (0x8 to 0xB), and a marker is followed by no more than a bounded number of data nibbles.

The detector keeps a data allowance. The allowance is refilled by every marker and is spent by each nibble that follows. The detector also counts the current run of consecutive 0xF nibbles. It declares a halt when the run grows longer than the allowance that was left when the run started. In other words, a halt is declared when data alone can no longer explain the run.

The block has two outputs. A one-cycle pulse marks the start of a halt. A level flag stays high until a nibble other than 0xF arrives. With the default allowance of seven nibbles, the marker-in-upper-nibble case (0xBF, 0xFF, 0xFF, 0xFF, then 0xF followed by a non-0xF nibble) is reported on its last byte.

Top module: `trace_halt_detector`

## Requirements
- R1: A synchronous active-low reset clears the outputs, the 0xF run count and the data allowance. Because the allowance is zero after reset, the first 0xF nibble after reset is a halt.
- R2: Each byte is processed as two nibbles. Bits [7:4] are handled before bits [3:0], and the state left by the upper nibble is the state the lower nibble starts from.
- R3: A marker nibble (upper two bits 10, so 0x8 to 0xB) sets the data allowance to DATA_NIB_MAX. It also ends any 0xF run.
- R4: Every nibble that is not a marker reduces the allowance by one. The allowance never goes below zero.
- R5: A 0xF nibble is a halt when the run it extends becomes longer than the allowance left at the start of that run. A run of 0xF nibbles that fits inside the allowance is treated as data.
- R6: Any nibble other than 0xF ends the run and clears the halted level. If the lower nibble of a byte is not 0xF, the level is low after that byte.
- R7: halt_pulse is high for exactly one cycle for a byte in which some nibble detects a halt while the level was low just before that nibble. Further 0xF nibbles after a halt produce no new pulse.
- R8: Both outputs are registered. They show the effect of the byte sampled at the previous rising edge and do not change between edges.
- R9: With DATA_NIB_MAX = 7, the sequence 0xBF, 0xFF, 0xFF, 0xFF, 0xF2 gives no pulse on its first four bytes and one pulse on the fifth byte. The level is low after the fifth byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one trace byte is taken at each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| trace_byte | input | BYTE_W | Trace byte; the upper nibble comes first in time |
| halt_pulse | output | 1 | One-cycle pulse when a halt is first detected |
| halted | output | 1 | High from a detected halt until a non-0xF nibble arrives |

## Verification
The bench builds two instances that see the same stream. The main instance uses DATA_NIB_MAX = 3, so every allowance boundary can be reached with only two or three bytes. This keeps full sweeps of the 256 byte values short: once straight after reset and once after a marker refill. F-runs of every length from zero up past twice the allowance are also driven. A second instance keeps the default of 7 so that the five-byte marker-in-upper-nibble sequence can be checked against fixed expected values. A long stream of random bytes, biased toward 0xF nibbles, is compared each cycle against an arithmetic model. The model tracks only the remaining allowance.

// File: rtl/thd_pkg.sv
// Package for the trace halt detector.
// Holds the nibble width, the halt code and the helper functions that
// classify a nibble. It assumes that status nibbles are four bits wide.
package thd_pkg;

    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] nib_t;

    localparam nib_t HALT_CODE = 4'hF;

    // True for the four marker codes 0x8..0xB (upper two bits are 10).
    function automatic logic is_marker(input nib_t n);
        return (n[3:2] == 2'b10);
    endfunction

    // True for the status code that means the core has stopped.
    function automatic logic is_halt_code(input nib_t n);
        return (n == HALT_CODE);
    endfunction

endpackage

// File: rtl/thd_nibble_step.sv
// Next-state logic for a single trace nibble (combinational only).
// It takes the tracking state and the halted level that hold before the
// nibble, and returns the state after it. It also reports a new detection,
// meaning a halt found while the level was still low.
// Assumes RUN_W can hold DATA_NIB_MAX+1 and BUD_W can hold DATA_NIB_MAX.
module thd_nibble_step
    import thd_pkg::*;
#(
    parameter int DATA_NIB_MAX = 7,
    parameter int RUN_W        = 4,
    parameter int BUD_W        = 3
) (
    input  nib_t             nib,
    input  logic [RUN_W-1:0] run_i,
    input  logic [BUD_W-1:0] allow_i,
    input  logic [BUD_W-1:0] budget_i,
    input  logic             halted_i,
    output logic [RUN_W-1:0] run_o,
    output logic [BUD_W-1:0] allow_o,
    output logic [BUD_W-1:0] budget_o,
    output logic             halted_o,
    output logic             trig_o
);

    localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(DATA_NIB_MAX + 1);
    localparam logic [BUD_W-1:0] BUD_FULL = BUD_W'(DATA_NIB_MAX);

    logic [RUN_W-1:0] run_inc;
    logic [BUD_W-1:0] allow_eff;
    logic [BUD_W-1:0] budget_dec;
    logic             over;

    // Saturating run increment and the allowance that applies to this run.
    always_comb begin
        run_inc    = (run_i == RUN_SAT) ? RUN_SAT : run_i + RUN_W'(1);
        allow_eff  = (run_i == '0) ? budget_i : allow_i;
        budget_dec = (budget_i == '0) ? '0 : budget_i - BUD_W'(1);
        over       = (run_inc > RUN_W'(allow_eff));
    end

    // Pick the next state from the nibble class: marker, halt code or other.
    always_comb begin
        run_o    = '0;
        allow_o  = allow_i;
        budget_o = budget_dec;
        halted_o = 1'b0;
        trig_o   = 1'b0;
        if (is_marker(nib)) begin
            budget_o = BUD_FULL;
        end else if (is_halt_code(nib)) begin
            run_o    = run_inc;
            allow_o  = allow_eff;
            halted_o = halted_i | over;
            trig_o   = over & ~halted_i;
        end
    end

endmodule

// File: rtl/thd_track_reg.sv
// Register stage for the run count, the latched run allowance and the
// remaining data allowance. Reset is synchronous and active low, and all
// three registers go to zero on reset.
module thd_track_reg #(
    parameter int RUN_W = 4,
    parameter int BUD_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RUN_W-1:0] run_d,
    input  logic [BUD_W-1:0] allow_d,
    input  logic [BUD_W-1:0] budget_d,
    output logic [RUN_W-1:0] run_q,
    output logic [BUD_W-1:0] allow_q,
    output logic [BUD_W-1:0] budget_q
);

    // Store the tracking state once per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= '0;
            allow_q  <= '0;
            budget_q <= '0;
        end else begin
            run_q    <= run_d;
            allow_q  <= allow_d;
            budget_q <= budget_d;
        end
    end

endmodule

// File: rtl/thd_flag_reg.sv
// Output register stage for the halted level and the detection pulse.
// The pulse input is the OR of the per-nibble detections in the current
// byte, so the pulse register holds it for exactly one cycle.
module thd_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic halted_d,
    input  logic pulse_d,
    output logic halted_q,
    output logic pulse_q
);

    // Register both outputs; synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            halted_q <= halted_d;
            pulse_q  <= pulse_d;
        end
    end

endmodule

// File: rtl/trace_halt_detector.sv
// Trace stream halt detector (top level).
// Each byte is split into nibbles, taken from the most significant one
// down, and they are chained through one step stage each within the cycle.
// A halt is declared when a run of 0xF nibbles outlasts the data allowance
// left by the last marker. Assumes BYTE_W is a multiple of four.
module trace_halt_detector
    import thd_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int DATA_NIB_MAX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] trace_byte,
    output logic              halt_pulse,
    output logic              halted
);

    localparam int NIBS  = BYTE_W / NIB_W;
    localparam int RUN_W = $clog2(DATA_NIB_MAX + 2);
    localparam int BUD_W = $clog2(DATA_NIB_MAX + 1);

    logic [RUN_W-1:0] run_q;
    logic [BUD_W-1:0] allow_q;
    logic [BUD_W-1:0] budget_q;

    logic [RUN_W-1:0] run_c    [NIBS+1];
    logic [BUD_W-1:0] allow_c  [NIBS+1];
    logic [BUD_W-1:0] budget_c [NIBS+1];
    logic             halted_c [NIBS+1];
    logic [NIBS-1:0]  trig_c;

    // Start of the nibble chain: the registered state.
    always_comb begin
        run_c[0]    = run_q;
        allow_c[0]  = allow_q;
        budget_c[0] = budget_q;
        halted_c[0] = halted;
    end

    // One step stage per nibble, the earliest nibble in the top bits.
    for (genvar i = 0; i < NIBS; i++) begin : g_nib
        thd_nibble_step #(
            .DATA_NIB_MAX(DATA_NIB_MAX),
            .RUN_W       (RUN_W),
            .BUD_W       (BUD_W)
        ) u_step (
            .nib     (trace_byte[BYTE_W-1-NIB_W*i -: NIB_W]),
            .run_i   (run_c[i]),
            .allow_i (allow_c[i]),
            .budget_i(budget_c[i]),
            .halted_i(halted_c[i]),
            .run_o   (run_c[i+1]),
            .allow_o (allow_c[i+1]),
            .budget_o(budget_c[i+1]),
            .halted_o(halted_c[i+1]),
            .trig_o  (trig_c[i])
        );
    end

    thd_track_reg #(
        .RUN_W(RUN_W),
        .BUD_W(BUD_W)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_d   (run_c[NIBS]),
        .allow_d (allow_c[NIBS]),
        .budget_d(budget_c[NIBS]),
        .run_q   (run_q),
        .allow_q (allow_q),
        .budget_q(budget_q)
    );

    thd_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .halted_d(halted_c[NIBS]),
        .pulse_d (|trig_c),
        .halted_q(halted),
        .pulse_q (halt_pulse)
    );

endmodule

// File: rtl/thd_checker.sv
// Property checker for trace_halt_detector. It is bound to the top level
// and watches the input byte, the registered allowance, the run count and
// both outputs.
module thd_checker #(
    parameter int BYTE_W       = 8,
    parameter int DATA_NIB_MAX = 7,
    parameter int RUN_W        = 4,
    parameter int BUD_W        = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] trace_byte,
    input logic [RUN_W-1:0]  run_q,
    input logic [BUD_W-1:0]  budget_q,
    input logic              halt_pulse,
    input logic              halted
);

    // R3
    marker_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_byte[3:2] == 2'b10) |=> (int'(budget_q) == DATA_NIB_MAX));

    // R4
    budget_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_byte[BYTE_W-1:BYTE_W-2] != 2'b10 && trace_byte[3:2] != 2'b10
         && budget_q >= BUD_W'(2) && BYTE_W == 8)
        |=> (int'(budget_q) == int'($past(budget_q)) - 2));

    // R5
    exhausted_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_byte[3:0] == 4'hF && trace_byte[BYTE_W-1:BYTE_W-4] == 4'hF
         && budget_q == '0) |=> halted);

    // R6
    level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_byte[3:0] != 4'hF) |=> (!halted && run_q == '0));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |-> (!$past(halted)
                        || $past(trace_byte[BYTE_W-1:BYTE_W-4]) != 4'hF));

endmodule

bind trace_halt_detector thd_checker #(
    .BYTE_W      (BYTE_W),
    .DATA_NIB_MAX(DATA_NIB_MAX),
    .RUN_W       (RUN_W),
    .BUD_W       (BUD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trace_byte(trace_byte),
    .run_q     (run_q),
    .budget_q  (budget_q),
    .halt_pulse(halt_pulse),
    .halted    (halted)
);

// File: tb/tb_trace_halt_detector.sv
// Bench: one small-allowance instance (3) swept hard, one default instance
// (7) for the fixed five-byte sequence. Expected values come from a model
// that tracks only the remaining allowance and the level.
module tb_trace_halt_detector;

    localparam int MAX_S = 3;
    localparam int MAX_D = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] trace_byte = 8'h00;
    logic       pulse_s, halted_s, pulse_d, halted_d;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int bud_s, bud_d;
    bit hal_s, hal_d;

    always #5 clk = ~clk;

    trace_halt_detector #(.BYTE_W(8), .DATA_NIB_MAX(MAX_S)) dut (
        .clk(clk), .rst_n(rst_n), .trace_byte(trace_byte),
        .halt_pulse(pulse_s), .halted(halted_s));

    trace_halt_detector #(.BYTE_W(8), .DATA_NIB_MAX(MAX_D)) dut_dflt (
        .clk(clk), .rst_n(rst_n), .trace_byte(trace_byte),
        .halt_pulse(pulse_d), .halted(halted_d));

    // Model of one nibble: a 0xF is a halt exactly when no allowance is left.
    function automatic void mstep(input logic [3:0] n, input int mx,
                                  inout int bud, inout bit hal, inout bit trig);
        if (n[3:2] == 2'b10) begin
            bud = mx;
            hal = 1'b0;
        end else if (n == 4'hF) begin
            if (bud == 0) begin
                if (!hal) trig = 1'b1;
                hal = 1'b1;
            end else begin
                bud = bud - 1;
            end
        end else begin
            if (bud > 0) bud = bud - 1;
            hal = 1'b0;
        end
    endfunction

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        trace_byte = 8'h00;
        @(negedge clk);
        @(posedge clk);
        #1;
        bud_s = 0; bud_d = 0; hal_s = 1'b0; hal_d = 1'b0;
        // R1: reset state of both outputs
        check("R1", "pulse after reset", pulse_s, 1'b0);
        check("R1", "level after reset", halted_s, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one byte, update the model, compare one step after the edge.
    task automatic send(input logic [7:0] b, input string tag);
        bit ts, td;
        @(negedge clk);
        trace_byte = b;
        ts = 1'b0; td = 1'b0;
        mstep(b[7:4], MAX_S, bud_s, hal_s, ts);
        mstep(b[3:0], MAX_S, bud_s, hal_s, ts);
        mstep(b[7:4], MAX_D, bud_d, hal_d, td);
        mstep(b[3:0], MAX_D, bud_d, hal_d, td);
        @(posedge clk);
        #1;
        check(tag, "pulse small", pulse_s, ts);
        check(tag, "level small", halted_s, hal_s);
        check(tag, "pulse dflt", pulse_d, td);
        check(tag, "level dflt", halted_d, hal_d);
    endtask

    // Watchdog: a hung run counts as a failure and still prints a summary.
    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();

        // R8: outputs hold between edges after new input is driven
        @(negedge clk);
        trace_byte = 8'hFF;
        #1;
        check("R8", "level before edge", halted_s, 1'b0);
        check("R8", "pulse before edge", pulse_s, 1'b0);
        do_reset();

        // R1: zero allowance after reset, the first 0xF is a halt
        send(8'h0F, "R1");

        // R2: nibble order, upper first
        do_reset();
        send(8'hF8, "R2");
        check("R2", "F8 pulse", pulse_s, 1'b1);
        check("R2", "F8 level", halted_s, 1'b0);
        do_reset();
        send(8'h8F, "R2");
        check("R2", "8F no pulse", pulse_s, 1'b0);

        // R4, R5: every byte value straight after reset
        for (int b = 0; b < 256; b++) begin
            do_reset();
            send(8'(b), "R5");
        end

        // R3, R4: every byte value after a marker refill (0x90 leaves MAX-1)
        for (int b = 0; b < 256; b++) begin
            do_reset();
            send(8'h90, "R3");
            send(8'(b), "R4");
        end

        // R5, R6: runs of 0xF nibbles of every length after a refill
        for (int len = 0; len <= 2 * MAX_S + 4; len++) begin
            do_reset();
            send(8'h0A, "R3");
            for (int k = 0; k < len / 2; k++) send(8'hFF, "R5");
            if (len % 2 == 1) send(8'h3F, "R5");
            send(8'h00, "R6");
            check("R6", "level cleared", halted_s, 1'b0);
        end

        // R7: repeated 0xFF after a halt gives a single pulse
        do_reset();
        send(8'hFF, "R7");
        check("R7", "first pulse", pulse_s, 1'b1);
        send(8'hFF, "R7");
        check("R7", "no repeat pulse", pulse_s, 1'b0);
        check("R7", "level held", halted_s, 1'b1);
        send(8'h0F, "R7");
        check("R7", "retrigger after clear", pulse_s, 1'b1);

        // R9: marker in upper nibble, allowance of seven
        do_reset();
        send(8'hBF, "R9");
        check("R9", "byte1 pulse", pulse_d, 1'b0);
        for (int k = 0; k < 3; k++) begin
            send(8'hFF, "R9");
            check("R9", "data pulse", pulse_d, 1'b0);
        end
        send(8'hF2, "R9");
        check("R9", "halt pulse", pulse_d, 1'b1);
        check("R9", "level after F2", halted_d, 1'b0);

        // R4, R5, R6: long random stream biased toward 0xF nibbles
        do_reset();
        lfsr = 16'hACE1;
        for (int n = 0; n < 20000; n++) begin
            logic [7:0] b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b[7:4] = (lfsr[2:0] < 3'd5) ? 4'hF : lfsr[7:4];
            b[3:0] = (lfsr[10:8] < 3'd5) ? 4'hF : lfsr[14:11];
            send(b, "R4");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule